// File: doc/BRIEF.md
# Selectable-Source Edge Interrupt Detector

This block is the pin-interrupt front end of a small microcontroller. It has eight channels. Each channel takes its source pin from one of two 8-bit GPIO input ports, port A or port D, and always uses the pin with the channel's own index. The block brings that pin into the system clock domain through a synchronizer. It watches for one edge, rising or falling, chosen per channel. When that edge appears, the channel's interrupt request output goes high for a single clock cycle. The downstream pending, priority and vectoring logic collects these pulses.

Software sets each channel's source port and edge polarity through two byte-wide control registers on a simple register bus. The bus has an address, a write strobe, write data and read data. When a channel's configuration changes, its edge history reloads from the newly selected source. Reconfiguration therefore never produces a request of its own.

Top module: `edge_irq_front`

## Requirements
- R1: A synchronous active-high reset clears both control registers and every request output to 0. After reset, every channel watches port A for falling edges.
- R2: The polarity register is at address 0xFCD and can be read and written. Bit x set to 1 makes channel x detect rising edges. Bit x set to 0 makes channel x detect falling edges.
- R3: The source register is at address 0xFCE and can be read and written. Bit x set to 0 selects port A pin x as the source of channel x. Bit x set to 1 selects port D pin x.
- R4: A read from any other address returns 0. A write to any other address changes neither control register.
- R5: Suppose a selected pin changes to the watched level between rising clock edges k-1 and k and then holds. The channel's request bit is high only during the cycle after edge k+2, and is high for exactly one cycle.
- R6: A selected pin pulse that lasts two clock periods always produces exactly one request.
- R7: An edge of the polarity a channel is not set to watch produces no request.
- R8: A transition on the pin of the unselected port produces no request on that channel.
- R9: Consider a register write that changes a channel's polarity or source bit. On the clock edge that commits the write, that channel issues no request. The channel's edge history then reloads from the newly selected synchronized pin, so the change itself never yields a request. Channels whose bits are unchanged keep working through the write.
- R10: Channels operate independently. Edges on several channels in the same cycle give requests on all of those channels in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_pins | input | 8 | Asynchronous port A pin levels |
| pd_pins | input | 8 | Asynchronous port D pin levels |
| cfg_addr | input | 12 | Register bus byte address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational from cfg_addr |
| irq_pulse | output | 8 | One-cycle request pulse per channel |

## Verification
A configuration write can land on the same clock edge at which a channel's synchronized pin edge would register a request. The bench arranges this by driving a rising edge on port A pins 4 and 7 and then timing a polarity write that flips only bit 4 so that it commits on the edge where both requests would appear. Channel 4 must stay silent, both on that edge and afterwards, because its history was reloaded. Channel 7 must still pulse in exactly its expected cycle. A second write moves a channel's source to a port whose pin is already at the active level, and the bench checks that no false request follows.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   // Polarity encoding of one bit of the polarity register
   typedef enum logic {
      POL_FALL = 1'b0,
      POL_RISE = 1'b1
   } eirq_pol_e;

   // Source encoding of one bit of the source register
   typedef enum logic {
      SRC_PORT_A = 1'b0,
      SRC_PORT_D = 1'b1
   } eirq_src_e;

   // Edge qualifier: current synchronized level against the level one cycle earlier
   function automatic logic eirq_edge_hit(input eirq_pol_e pol,
                                          input logic      cur,
                                          input logic      prev);
      if (pol == POL_RISE) eirq_edge_hit = cur & ~prev;
      else                 eirq_edge_hit = ~cur & prev;
   endfunction

   function automatic logic eirq_pick(input eirq_src_e src,
                                      input logic      a_lvl,
                                      input logic      d_lvl);
      eirq_pick = (src == SRC_PORT_D) ? d_lvl : a_lvl;
   endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("eirq_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[LAST];

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
   parameter int               NUM_CH    = 8,
   parameter int               DATA_W    = 8,
   parameter int               ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] POL_ADDR = 12'hFCD,
   parameter logic [ADDR_W-1:0] SRC_ADDR = 12'hFCE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] pol_q,
   output logic [NUM_CH-1:0] src_q,
   output logic [NUM_CH-1:0] src_next,
   output logic [NUM_CH-1:0] cfg_touch
);

   localparam int PAD_W = DATA_W - NUM_CH;

   if (NUM_CH > DATA_W) begin : g_bad_fit
      $error("eirq_regs: NUM_CH must not exceed DATA_W");
   end
   if (POL_ADDR == SRC_ADDR) begin : g_bad_map
      $error("eirq_regs: register addresses must differ");
   end

   logic              hit_pol, hit_src;
   logic [NUM_CH-1:0] wbits;
   logic [NUM_CH-1:0] pol_next;

   assign hit_pol  = we && (addr == POL_ADDR);
   assign hit_src  = we && (addr == SRC_ADDR);
   assign wbits    = wdata[NUM_CH-1:0];
   assign pol_next = hit_pol ? wbits : pol_q;
   assign src_next = hit_src ? wbits : src_q;

   // Channels whose configuration this cycle's write alters
   assign cfg_touch = (pol_next ^ pol_q) | (src_next ^ src_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_q <= '0;
         src_q <= '0;
      end else begin
         pol_q <= pol_next;
         src_q <= src_next;
      end
   end

   if (PAD_W > 0) begin : g_pad
      always_comb begin
         if (addr == POL_ADDR)      rdata = {{PAD_W{1'b0}}, pol_q};
         else if (addr == SRC_ADDR) rdata = {{PAD_W{1'b0}}, src_q};
         else                       rdata = '0;
      end
   end else begin : g_nopad
      always_comb begin
         if (addr == POL_ADDR)      rdata = pol_q;
         else if (addr == SRC_ADDR) rdata = src_q;
         else                       rdata = '0;
      end
   end

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
   import eirq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic a_lvl,
   input  logic d_lvl,
   input  logic pol,
   input  logic src,
   input  logic src_new,
   input  logic reload,
   output logic req
);

   logic cur, prev_q, hit, req_q;

   assign cur = eirq_pick(eirq_src_e'(src), a_lvl, d_lvl);
   assign hit = eirq_edge_hit(eirq_pol_e'(pol), cur, prev_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         req_q  <= 1'b0;
      end else if (reload) begin
         prev_q <= eirq_pick(eirq_src_e'(src_new), a_lvl, d_lvl);
         req_q  <= 1'b0;
      end else begin
         prev_q <= cur;
         req_q  <= hit;
      end
   end

   assign req = req_q;

endmodule

// File: rtl/edge_irq_front.sv
module edge_irq_front #(
   parameter int                NUM_CH      = 8,
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 12,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] POL_ADDR    = 12'hFCD,
   parameter logic [ADDR_W-1:0] SRC_ADDR    = 12'hFCE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] pa_pins,
   input  logic [NUM_CH-1:0] pd_pins,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [NUM_CH-1:0] irq_pulse
);

   logic [NUM_CH-1:0] pa_s, pd_s;
   logic [NUM_CH-1:0] pol_q, src_q, src_next, cfg_touch;

   eirq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst(rst), .async_i(pa_pins), .sync_o(pa_s)
   );

   eirq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_d (
      .clk(clk), .rst(rst), .async_i(pd_pins), .sync_o(pd_s)
   );

   eirq_regs #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .POL_ADDR(POL_ADDR), .SRC_ADDR(SRC_ADDR)
   ) u_regs (
      .clk(clk), .rst(rst),
      .addr(cfg_addr), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
      .pol_q(pol_q), .src_q(src_q), .src_next(src_next), .cfg_touch(cfg_touch)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      eirq_chan u_chan (
         .clk(clk), .rst(rst),
         .a_lvl(pa_s[c]), .d_lvl(pd_s[c]),
         .pol(pol_q[c]), .src(src_q[c]), .src_new(src_next[c]),
         .reload(cfg_touch[c]),
         .req(irq_pulse[c])
      );
   end

endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
   parameter int                NUM_CH   = 8,
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] POL_ADDR = 12'hFCD,
   parameter logic [ADDR_W-1:0] SRC_ADDR = 12'hFCE
) (
   input logic              clk,
   input logic              rst,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [NUM_CH-1:0] pol_q,
   input logic [NUM_CH-1:0] src_q,
   input logic [NUM_CH-1:0] irq
);

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (pol_q == '0 && src_q == '0 && irq == '0));

   p_pol_write_r2: assert property (@(posedge clk) disable iff (rst)
      (we && addr == POL_ADDR) |=> pol_q == $past(wdata[NUM_CH-1:0]));

   p_src_write_r3: assert property (@(posedge clk) disable iff (rst)
      (we && addr == SRC_ADDR) |=> src_q == $past(wdata[NUM_CH-1:0]));

   p_stray_write_r4: assert property (@(posedge clk) disable iff (rst)
      (we && addr != POL_ADDR && addr != SRC_ADDR) |=> ($stable(pol_q) && $stable(src_q)));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      (irq != '0) |=> ((irq & $past(irq)) == '0));

   p_pol_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (we && addr == POL_ADDR && (wdata[NUM_CH-1:0] ^ pol_q) != '0)
      |=> ((irq & $past(wdata[NUM_CH-1:0] ^ pol_q)) == '0));

   p_src_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (we && addr == SRC_ADDR && (wdata[NUM_CH-1:0] ^ src_q) != '0)
      |=> ((irq & $past(wdata[NUM_CH-1:0] ^ src_q)) == '0));

endmodule

bind edge_irq_front eirq_chk #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .POL_ADDR(POL_ADDR), .SRC_ADDR(SRC_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
   .pol_q(pol_q), .src_q(src_q), .irq(irq_pulse)
);

// File: tb/sim_edge_irq_front.sv
module sim_edge_irq_front;

   localparam int CLK_P = 10;
   localparam logic [11:0] A_POL = 12'hFCD;
   localparam logic [11:0] A_SRC = 12'hFCE;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pa_pins = '0;
   logic [7:0]  pd_pins = '0;
   logic [11:0] cfg_addr = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [7:0]  irq_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   edge_irq_front u0 (
      .clk(clk), .rst(rst), .pa_pins(pa_pins), .pd_pins(pd_pins),
      .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .irq_pulse(irq_pulse)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0; cfg_addr = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] v);
      cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic do_reset(input logic [7:0] a_lvl, input logic [7:0] d_lvl);
      rst = 1'b1; pa_pins = a_lvl; pd_pins = d_lvl;
      tick(); tick();
      rst = 1'b0;
      tick(); tick(); tick();
   endtask

   // Called right after driving pins at a falling clock edge
   task automatic expect_pulse(input logic [7:0] exp, input string tag);
      tick(); tick();
      chk(irq_pulse, 8'h00, {tag, " early"});
      tick();
      chk(irq_pulse, exp, tag);
      tick();
      chk(irq_pulse, 8'h00, {tag, " width"});
   endtask

   task automatic quiet(input int cycles, input string tag);
      for (int i = 0; i < cycles; i++) begin
         tick();
         chk(irq_pulse, 8'h00, tag);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset(8'h00, 8'h00);
      rd(A_POL, v); chk(v, 8'h00, "R1 polarity reset");
      rd(A_SRC, v); chk(v, 8'h00, "R1 source reset");
      chk(irq_pulse, 8'h00, "R1 request reset");
   endtask

   task automatic t_regs();
      logic [7:0] v;
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'hA5);
      wr(A_SRC, 8'h3C);
      rd(A_POL, v); chk(v, 8'hA5, "R2 polarity readback");
      rd(A_SRC, v); chk(v, 8'h3C, "R3 source readback");
      quiet(4, "R9 config with idle pins");
   endtask

   task automatic t_other();
      logic [7:0] v;
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'h5A);
      wr(12'hFCC, 8'hFF);
      wr(12'hFCF, 8'hFF);
      rd(12'hFCC, v); chk(v, 8'h00, "R4 stray read");
      rd(12'h000, v); chk(v, 8'h00, "R4 stray read low");
      rd(A_POL, v); chk(v, 8'h5A, "R4 polarity untouched");
      rd(A_SRC, v); chk(v, 8'h00, "R4 source untouched");
   endtask

   task automatic t_falling();
      do_reset(8'h00, 8'h00);
      pa_pins = 8'hFF;
      quiet(6, "R7 rising ignored in falling mode");
      pa_pins = 8'hFB;
      expect_pulse(8'h04, "R5 falling edge ch2");
   endtask

   task automatic t_rising();
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'hFF);
      tick();
      pa_pins = 8'h20;
      expect_pulse(8'h20, "R5 rising edge ch5");
      pa_pins = 8'h00;
      quiet(5, "R7 falling ignored in rising mode");
   endtask

   task automatic t_port_d();
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'hFF);
      wr(A_SRC, 8'h0F);
      tick();
      pd_pins = 8'h02;
      expect_pulse(8'h02, "R3 port D ch1");
      pa_pins = 8'h02;
      quiet(5, "R8 port A ignored on ch1");
      pa_pins = 8'h42;
      expect_pulse(8'h40, "R3 port A ch6");
      pd_pins = 8'h42;
      quiet(5, "R8 port D ignored on ch6");
   endtask

   task automatic t_short();
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'hFF);
      tick();
      pa_pins = 8'h08;
      tick(); tick();
      pa_pins = 8'h00;
      chk(irq_pulse, 8'h00, "R6 two-cycle pulse early");
      tick();
      chk(irq_pulse, 8'h08, "R6 two-cycle pulse caught");
      quiet(5, "R6 single request");
   endtask

   task automatic t_multi();
      do_reset(8'h00, 8'h00);
      tick();
      wr(A_POL, 8'hFF);
      tick();
      pa_pins = 8'h81;
      expect_pulse(8'h81, "R10 simultaneous ch0 ch7");
   endtask

   task automatic t_coincide();
      do_reset(8'h00, 8'hFF);
      tick();
      wr(A_POL, 8'hFF);
      tick(); tick();
      // source move onto a port whose pin already sits high
      wr(A_SRC, 8'h01);
      quiet(5, "R9 source change no false edge ch0");
      // edge on ch4 and ch7, polarity of ch4 flipped on the edge that registers it
      pa_pins = 8'h90;
      tick(); tick();
      wr(A_POL, 8'hEF);
      chk(irq_pulse, 8'h80, "R9 coincident write keeps ch7 drops ch4");
      quiet(5, "R9 ch4 history reloaded");
      pa_pins = 8'h80;
      expect_pulse(8'h10, "R9 ch4 falling after change");
   endtask

   initial begin
      #(CLK_P * 20000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_regs();
      t_other();
      t_falling();
      t_rising();
      t_port_d();
      t_short();
      t_multi();
      t_coincide();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule